// File: doc/BRIEF.md
# Serial Shift Register Port

This block turns one byte into a serial bit stream, or builds one byte from a serial bit stream. It uses a two-wire port: one pin carries the serial clock and the other carries the serial data. The host processor loads the byte through a write strobe and fetches it through a read strobe. Every access of either kind starts a new transfer of eight bits. A completion flag reports that the eighth bit has been handled.

A three-bit mode input picks the direction and the clock source. The clock source can be the system clock, a rate tick from a companion timer, or an external clock applied to the clock pin. One extra mode shifts the byte out at the timer rate for ever, recirculating it. When the clock comes from inside the block, the block drives the clock pin and it idles high. When the clock is external, the pin is an input: it passes through a synchroniser and its edges are detected inside the clock domain.

Mode encodings:
- 000: off.
- 001: in, timer rate.
- 010: in, system clock.
- 011: in, external clock.
- 100: out, timer rate, free-running.
- 101: out, timer rate.
- 110: out, system clock.
- 111: out, external clock.

The sequencer has four named states:
- IDLE: the block is off, or no transfer has been started since reset.
- HIGH: the serial clock is high.
- LOW: the serial clock is low.
- DONE: the transfer is complete and the clock rests high.

The sequencer has these named transitions:
- start: any state goes to HIGH on an access, in a mode other than off.
- fall: HIGH goes to LOW on a step.
- rise: LOW goes back to HIGH on a step.
- finish: LOW goes to DONE on the eighth rise, except in the free-running mode.
- disable: any state goes to IDLE in mode 000.

Top module: `serial_shift_port`

## Requirements
- R1: After reset, the read byte is 0x00, the completion flag is 0, the serial clock output is 1 and the serial data output is 0.
- R2: A write strobe loads the byte, and it is readable on the next cycle. Any access, read or write, clears the completion flag and starts a new count of eight bits.
- R3: In mode 000, the serial clock output stays high, the clock output enable is 0, the completion flag stays 0 and the stored byte does not change.
- R4: In mode 110, the clock falls on the first cycle after the access edge. After that it toggles on every cycle. The data pin shows the bits MSB first; each bit appears on a falling edge and is held while the clock is low. Each bit sent is rotated back into the LSB, so the stored byte is unchanged after eight bits. The flag sets 16 cycles after the access edge.
- R5: In mode 010, the data pin is sampled at each rise of the serial clock and enters at the LSB. After eight bits, the byte holds the sampled bits with the first bit at the MSB.
- R6: In modes 001 and 101, each rate tick makes exactly one clock edge. Without ticks, the clock stays high and no bit moves.
- R7: In modes 011 and 111, the clock output enable is 0. Edges on the clock pin take effect after two synchroniser stages. Output bits change on falling edges, input bits are sampled on rising edges, and the flag sets after the eighth rising edge.
- R8: In mode 100, the clock keeps toggling at the tick rate, the byte recirculates MSB first, and the flag never sets.
- R9: Once the flag is set, the internally generated clock stays high and the byte does not change until the next access.
- R10: An access made during a transfer, or after one, restarts the count. The flag sets 16 system-clock steps after that access and not before.
- R11: The clock output enable is 1 in modes 001, 010, 100, 101 and 110, and 0 in modes 000, 011 and 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_sel | input | 3 | Direction and clock source select |
| acc_wr | input | 1 | Host write strobe, loads wdata |
| acc_rd | input | 1 | Host read strobe |
| wdata | input | 8 | Byte to load |
| rdata | output | 8 | Current shift register byte |
| timer_tick | input | 1 | One-cycle rate tick from the companion timer |
| sclk_i | input | 1 | Clock pin level (external source) |
| sclk_o | output | 1 | Driven clock pin level |
| sclk_oe | output | 1 | Clock pin output enable |
| sdat_i | input | 1 | Serial data in |
| sdat_o | output | 1 | Serial data out |
| xfer_done | output | 1 | Completion flag |

## Verification
An access is taken on edge E0. With the system clock as source, the first falling edge of the serial clock, and the MSB on the data pin, are visible after edge E1. Bit k is sampled at edge E(2k+2), and the flag rises after edge E16. With the timer as source, each clock step is due on the edge that samples the tick. With an external clock, the step is due three edges after the pin changes, so the bench holds each pin level for five cycles. All outputs are sampled on the falling edge of the system clock, and each check is placed at the counted edge.

// File: rtl/ssp_pkg.sv
`timescale 1ns/1ps
package ssp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_HIGH,
        ST_LOW,
        ST_DONE
    } ssp_state_e;

    typedef enum logic [1:0] {
        SRC_NONE,
        SRC_TIMER,
        SRC_SYS,
        SRC_EXT
    } ssp_src_e;

    // Clock source selected by the three-bit mode field.
    function automatic ssp_src_e src_of(input logic [2:0] m);
        ssp_src_e s;
        unique case (m)
            3'b000:                  s = SRC_NONE;
            3'b001, 3'b100, 3'b101:  s = SRC_TIMER;
            3'b010, 3'b110:          s = SRC_SYS;
            default:                 s = SRC_EXT;
        endcase
        return s;
    endfunction

    function automatic logic is_free(input logic [2:0] m);
        return (m == 3'b100);
    endfunction

    function automatic logic is_out(input logic [2:0] m);
        return m[2];
    endfunction

endpackage

// File: rtl/ssp_edge_sync.sv
`timescale 1ns/1ps
module ssp_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin,
    output logic rise,
    output logic fall
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sync_q;
    logic              prev_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= pin;
                end
            end else begin : g_next
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) sync_q[g] <= 1'b1;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b1;
        else        prev_q <= sync_q[LAST];
    end

    always_comb begin
        rise = sync_q[LAST] & ~prev_q;
        fall = ~sync_q[LAST] & prev_q;
    end

    // A detected edge must leave the synchronised level it announces
    AST_EDGE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> prev_q);   // R7

endmodule

// File: rtl/ssp_seq.sv
`timescale 1ns/1ps
module ssp_seq
    import ssp_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] mode_sel,
    input  logic       access,
    input  logic       timer_tick,
    input  logic       ext_rise,
    input  logic       ext_fall,
    output logic       ev_fall,
    output logic       ev_rise,
    output logic       sclk_o,
    output logic       sclk_oe,
    output logic       xfer_done
);
    localparam int              CNT_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(DATA_W - 1);

    ssp_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d;
    ssp_src_e         src;
    logic             free_run;
    logic             step_int;
    logic             fall_ok;
    logic             rise_ok;
    logic             go_fall;
    logic             go_rise;

    always_comb begin
        src      = src_of(mode_sel);
        free_run = is_free(mode_sel);
        step_int = (src == SRC_SYS) | ((src == SRC_TIMER) & timer_tick);
        fall_ok  = (src == SRC_EXT) ? ext_fall : step_int;
        rise_ok  = (src == SRC_EXT) ? ext_rise : step_int;
    end

    // Next-state logic: disable, start, fall, rise, finish
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        go_fall = 1'b0;
        go_rise = 1'b0;
        if (src == SRC_NONE) begin
            state_d = ST_IDLE;
            cnt_d   = '0;
        end else if (access) begin
            state_d = ST_HIGH;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_IDLE, ST_DONE: begin
                    state_d = state_q;
                end
                ST_HIGH: begin
                    if (fall_ok) begin
                        state_d = ST_LOW;
                        go_fall = 1'b1;
                    end
                end
                ST_LOW: begin
                    if (rise_ok) begin
                        go_rise = 1'b1;
                        cnt_d   = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
                        if (cnt_q == CNT_LAST && !free_run) state_d = ST_DONE;
                        else                                state_d = ST_HIGH;
                    end
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    // Outputs
    always_comb begin
        sclk_o    = (state_q != ST_LOW);
        sclk_oe   = (src == SRC_TIMER) || (src == SRC_SYS);
        xfer_done = (state_q == ST_DONE);
        ev_fall   = go_fall;
        ev_rise   = go_rise;
    end

    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        access |=> !xfer_done);   // R10

    AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !access && src != SRC_NONE) |=> (xfer_done && sclk_o));   // R9

    AST_FREE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (free_run && !xfer_done) |=> !xfer_done);   // R8

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (src == SRC_NONE) |=> (sclk_o && !xfer_done));   // R3

    AST_ONE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        !(ev_fall && ev_rise));   // R6

endmodule

// File: rtl/ssp_shreg.sv
`timescale 1ns/1ps
module ssp_shreg #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] wdata,
    input  logic              dir_out,
    input  logic              ev_fall,
    input  logic              ev_rise,
    input  logic              sdat_i,
    output logic [DATA_W-1:0] rdata,
    output logic              sdat_o
);
    localparam int MSB = DATA_W - 1;

    logic [DATA_W-1:0] sreg_q;
    logic              out_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
            out_q  <= 1'b0;
        end else if (load) begin
            sreg_q <= wdata;
        end else begin
            if (ev_rise && !dir_out) begin
                sreg_q <= {sreg_q[MSB-1:0], sdat_i};
            end
            if (ev_fall && dir_out) begin
                out_q  <= sreg_q[MSB];
                sreg_q <= {sreg_q[MSB-1:0], sreg_q[MSB]};
            end
        end
    end

    always_comb begin
        rdata  = sreg_q;
        sdat_o = out_q;
    end

    AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !ev_fall && !ev_rise) |=> $stable(sreg_q));   // R3

    AST_IN_AT_LSB: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_rise && !dir_out && !load) |=> (sreg_q[0] == $past(sdat_i)));   // R5

    AST_OUT_IS_MSB: assert property (@(posedge clk) disable iff (!rst_n)
        (ev_fall && dir_out && !load) |=> (out_q == sreg_q[0]));   // R4

endmodule

// File: rtl/serial_shift_port.sv
`timescale 1ns/1ps
module serial_shift_port
    import ssp_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_sel,
    input  logic              acc_wr,
    input  logic              acc_rd,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              timer_tick,
    input  logic              sclk_i,
    output logic              sclk_o,
    output logic              sclk_oe,
    input  logic              sdat_i,
    output logic              sdat_o,
    output logic              xfer_done
);
    logic access;
    logic ext_rise;
    logic ext_fall;
    logic ev_fall;
    logic ev_rise;
    logic dir_out;

    always_comb begin
        access  = acc_wr | acc_rd;
        dir_out = is_out(mode_sel);
    end

    ssp_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (sclk_i),
        .rise (ext_rise),
        .fall (ext_fall)
    );

    ssp_seq #(.DATA_W(DATA_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .access    (access),
        .timer_tick(timer_tick),
        .ext_rise  (ext_rise),
        .ext_fall  (ext_fall),
        .ev_fall   (ev_fall),
        .ev_rise   (ev_rise),
        .sclk_o    (sclk_o),
        .sclk_oe   (sclk_oe),
        .xfer_done (xfer_done)
    );

    ssp_shreg #(.DATA_W(DATA_W)) u_shreg (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (acc_wr),
        .wdata  (wdata),
        .dir_out(dir_out),
        .ev_fall(ev_fall),
        .ev_rise(ev_rise),
        .sdat_i (sdat_i),
        .rdata  (rdata),
        .sdat_o (sdat_o)
    );

    AST_WRITE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_wr |=> (rdata == $past(wdata)));   // R2

endmodule

// File: tb/test_serial_shift_port.sv
`timescale 1ns/1ps
module test_serial_shift_port;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] mode_sel = 3'b000;
    logic       acc_wr = 1'b0;
    logic       acc_rd = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       timer_tick = 1'b0;
    logic       sclk_i = 1'b1;
    logic       sclk_o;
    logic       sclk_oe;
    logic       sdat_i = 1'b0;
    logic       sdat_o;
    logic       xfer_done;

    int n_chk = 0;
    int n_err = 0;

    always #10 clk = ~clk;

    serial_shift_port i_serial_shift_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .mode_sel  (mode_sel),
        .acc_wr    (acc_wr),
        .acc_rd    (acc_rd),
        .wdata     (wdata),
        .rdata     (rdata),
        .timer_tick(timer_tick),
        .sclk_i    (sclk_i),
        .sclk_o    (sclk_o),
        .sclk_oe   (sclk_oe),
        .sdat_i    (sdat_i),
        .sdat_o    (sdat_o),
        .xfer_done (xfer_done)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic set_mode(input logic [2:0] m);
        @(negedge clk);
        mode_sel = m;
    endtask

    // Access is sampled at edge E0; returns at the falling edge after E0
    task automatic do_access(input logic wr, input logic [7:0] d);
        @(negedge clk);
        acc_wr = wr;
        acc_rd = ~wr;
        wdata  = d;
        @(negedge clk);
        acc_wr = 1'b0;
        acc_rd = 1'b0;
    endtask

    task automatic t_reset;
        chk("R1 rdata", rdata, 8'h00);
        chk("R1 done", xfer_done, 1'b0);
        chk("R1 sclk", sclk_o, 1'b1);
        chk("R1 sdat", sdat_o, 1'b0);
    endtask

    task automatic t_off;
        int lows = 0;
        int dn = 0;
        set_mode(3'b000);
        do_access(1'b1, 8'hA5);
        chk("R2 load", rdata, 8'hA5);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (!sclk_o) lows++;
            if (xfer_done) dn++;
        end
        chk("R3 no clock", lows, 0);
        chk("R3 no done", dn, 0);
        chk("R3 byte held", rdata, 8'hA5);
        chk("R11 oe off", sclk_oe, 1'b0);
    endtask

    task automatic t_sys_out;
        int lows = 0;
        logic [7:0] bits = '0;
        set_mode(3'b110);
        do_access(1'b1, 8'hB4);
        chk("R11 oe sys out", sclk_oe, 1'b1);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (k == 1) chk("R4 first fall", sclk_o, 1'b0);
            if (!sclk_o) begin
                bits = {bits[6:0], sdat_o};
                lows++;
            end
            if (k == 15) chk("R4 done early", xfer_done, 1'b0);
            if (k == 16) chk("R4 done due", xfer_done, 1'b1);
        end
        chk("R4 low count", lows, 8);
        chk("R4 bits msb first", bits, 8'hB4);
        chk("R4 byte restored", rdata, 8'hB4);
        lows = 0;
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!sclk_o) lows++;
        end
        chk("R9 clock stopped", lows, 0);
        chk("R9 done held", xfer_done, 1'b1);
        chk("R9 byte held", rdata, 8'hB4);
    endtask

    task automatic t_restart;
        do_access(1'b0, 8'h00);
        chk("R10 read clears", xfer_done, 1'b0);
        chk("R2 read keeps byte", rdata, 8'hB4);
        do_access(1'b1, 8'h81);
        repeat (3) @(negedge clk);
        do_access(1'b0, 8'h00);
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (k == 15) chk("R10 no early done", xfer_done, 1'b0);
            if (k == 16) chk("R10 done after restart", xfer_done, 1'b1);
        end
        chk("R10 rotation total", rdata, 8'h06);
    endtask

    task automatic t_sys_in;
        int idx = 7;
        logic [7:0] pat = 8'h6C;
        sdat_i = 1'b0;
        set_mode(3'b010);
        do_access(1'b1, 8'h00);
        chk("R11 oe sys in", sclk_oe, 1'b1);
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            if (!sclk_o && idx >= 0) begin
                sdat_i = pat[idx];
                idx--;
            end
            if (k == 16) chk("R5 done", xfer_done, 1'b1);
        end
        chk("R5 byte in", rdata, 8'h6C);
    endtask

    task automatic t_timer;
        int lows = 0;
        logic [7:0] bits = '0;
        timer_tick = 1'b0;
        set_mode(3'b101);
        do_access(1'b1, 8'h81);
        for (int k = 0; k < 10; k++) begin
            @(negedge clk);
            if (!sclk_o) lows++;
        end
        chk("R6 no tick no clock", lows, 0);
        chk("R6 byte still", rdata, 8'h81);
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            timer_tick = 1'b1;
            @(negedge clk);
            timer_tick = 1'b0;
            chk("R6 one edge per tick", sclk_o, (i % 2 == 0) ? 1'b0 : 1'b1);
            if (!sclk_o) bits = {bits[6:0], sdat_o};
            @(negedge clk);
        end
        chk("R6 done", xfer_done, 1'b1);
        chk("R6 bits", bits, 8'h81);
    endtask

    task automatic t_free;
        int lows = 0;
        int dn = 0;
        logic [15:0] bits = '0;
        set_mode(3'b100);
        timer_tick = 1'b1;
        do_access(1'b1, 8'h3C);
        chk("R11 oe free", sclk_oe, 1'b1);
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (!sclk_o) begin
                if (lows < 16) bits = {bits[14:0], sdat_o};
                lows++;
            end
            if (xfer_done) dn++;
        end
        timer_tick = 1'b0;
        chk("R8 never done", dn, 0);
        chk("R8 keeps running", lows, 20);
        chk("R8 recirculates", bits, 16'h3C3C);
        set_mode(3'b000);
        @(negedge clk);
        chk("R3 off stops clock", sclk_o, 1'b1);
    endtask

    task automatic t_ext_out;
        logic [7:0] bits = '0;
        sclk_i = 1'b1;
        set_mode(3'b111);
        do_access(1'b1, 8'hC3);
        chk("R7 oe ext", sclk_oe, 1'b0);
        chk("R11 oe ext", sclk_oe, 1'b0);
        for (int b = 0; b < 8; b++) begin
            sclk_i = 1'b0;
            repeat (5) @(negedge clk);
            bits = {bits[6:0], sdat_o};
            sclk_i = 1'b1;
            repeat (5) @(negedge clk);
            if (b == 6) chk("R7 not done early", xfer_done, 1'b0);
        end
        chk("R7 done ext out", xfer_done, 1'b1);
        chk("R7 bits ext out", bits, 8'hC3);
    endtask

    task automatic t_ext_in;
        logic [7:0] pat = 8'h5A;
        set_mode(3'b011);
        do_access(1'b1, 8'h00);
        for (int b = 0; b < 8; b++) begin
            sdat_i = pat[7-b];
            sclk_i = 1'b0;
            repeat (5) @(negedge clk);
            sclk_i = 1'b1;
            repeat (5) @(negedge clk);
        end
        chk("R7 done ext in", xfer_done, 1'b1);
        chk("R7 byte ext in", rdata, 8'h5A);
    endtask

    initial begin
        #(20 * 100000);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_off();
        t_sys_out();
        t_restart();
        t_sys_in();
        t_timer();
        t_free();
        t_ext_out();
        t_ext_in();
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule